// File: doc/BRIEF.md
# Edge-Pair Window Timer

This block watches one asynchronous digital input and decides whether consecutive rising edges on it arrive close together. A rising edge seen while the block is idle arms a down-counter loaded with a fixed window length (240 clocks by default, which is 20 µs at a 12 MHz clock). Any further rising edge that arrives while that window is still open is a capture: the block emits a one-cycle capture pulse and pulls its status output low. When the window runs out, the block emits a one-cycle expiry pulse, drives the status output high and goes back to idle, so the next rising edge opens a fresh window with no outside help.

A falling edge on the input always drives the status output high. The input is brought into the clock domain through a synchronizer, and edges are taken from the synchronized value, so each transition is one single-cycle event. A capture does not restart the window, and every further rising edge inside the same window gives another capture pulse.

Top module: `edge_gap_timer`

## Requirements
- R1: The input passes through a two-flop synchronizer plus one edge-history flop. A transition applied before clock edge k is acted on at edge k+2, and its output effects are visible after that edge.
- R2: A rising edge while idle loads the counter with PERIOD and starts it counting down by one per clock.
- R3: Only rising edges arm or capture; a falling edge never arms the window and never gives a capture pulse.
- R4: A rising edge while the window is armed gives a capture pulse that is high for exactly one cycle.
- R5: Whenever a capture pulse is high, the status output is low, having been driven low at the same edge.
- R6: With no capture at that edge, the status output is high when the expiry pulse is high. If a capture and expiry fall on the same edge, the status output goes low.
- R7: The expiry pulse is one cycle wide and is high in the cycle after the edge that is exactly PERIOD clocks after the arming edge. After it, the block is idle, and the next rising edge arms a new window without a capture.
- R8: A falling edge drives the status output high.
- R9: The rising edge that arms the window never gives a capture pulse.
- R10: A capture does not reload the counter. The window still ends PERIOD clocks after the arming edge, and each further rising edge inside it gives its own capture pulse.
- R11: Synchronous reset returns the block to idle, clears the synchronizer, both pulses low and sets the status output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gap_in | input | 1 | Monitored input, asynchronous to clk |
| gap_status | output | 1 | Status level: low after a close edge pair, high after a falling edge or an expiry |
| capture_pulse | output | 1 | One-cycle pulse for a rising edge inside an armed window |
| expire_pulse | output | 1 | One-cycle pulse at the end of a window |

## Verification
The bench targets the window boundary. A second rising edge that lands on the last counted edge must capture in the same cycle as the expiry and leave the status low. An edge one clock later must re-arm quietly. A design with an off-by-one counter would capture the second edge or miss the first. Stacked rising edges inside one window test that a capture neither restarts the window nor suppresses later captures; a reloading counter would move the expiry pulse late. The bench also checks that the arming edge alone produces no capture, and that a falling edge raises the status mid-window. A design that took falling edges as triggers, or that left pulses stuck for two cycles, would show up as extra or stretched pulses against the bench's cycle model.

// File: rtl/egt_pkg.sv
package egt_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } egt_edges_t;

  function automatic int unsigned egt_next_count(input int unsigned cur,
                                                 input logic          arm,
                                                 input int unsigned period);
    if (arm)           return period;
    else if (cur != 0) return cur - 1;
    else               return 0;
  endfunction

  function automatic logic egt_is_last(input int unsigned cur);
    return cur == 1;
  endfunction

  function automatic logic egt_next_status(input logic cur,
                                           input logic cap,
                                           input logic fall,
                                           input logic expire);
    if (cap)                 return 1'b0;
    else if (fall || expire) return 1'b1;
    else                     return cur;
  endfunction

endpackage

// File: rtl/egt_edge_sync.sv
module egt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 async_in,
  output egt_pkg::egt_edges_t  edges
);
  logic [STAGES-1:0] chain_q;
  logic              hist_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b0;
    else     hist_q <= chain_q[STAGES-1];
  end

  always_comb begin
    edges.rise = chain_q[STAGES-1] & ~hist_q;
    edges.fall = ~chain_q[STAGES-1] & hist_q;
  end
endmodule

// File: rtl/egt_window_ctr.sv
module egt_window_ctr #(
  parameter int PERIOD = 240,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  output logic             armed,
  output logic             arm_evt,
  output logic             cap_evt,
  output logic             expire_evt,
  output logic [CNT_W-1:0] count,
  output logic             cap_q,
  output logic             tc_q
);
  import egt_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  assign armed      = (cnt_q != '0);
  assign arm_evt    = rise & ~armed;
  assign cap_evt    = rise & armed;
  assign expire_evt = armed & egt_is_last(int'(cnt_q));
  assign count      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cap_q <= 1'b0;
      tc_q  <= 1'b0;
    end else begin
      cnt_q <= CNT_W'(egt_next_count(int'(cnt_q), arm_evt, PERIOD));
      cap_q <= cap_evt;
      tc_q  <= expire_evt;
    end
  end
endmodule

// File: rtl/egt_status.sv
module egt_status (
  input  logic clk,
  input  logic rst,
  input  logic cap_evt,
  input  logic fall_evt,
  input  logic expire_evt,
  output logic status_q
);
  import egt_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) status_q <= 1'b1;
    else     status_q <= egt_next_status(status_q, cap_evt, fall_evt, expire_evt);
  end
endmodule

// File: rtl/edge_gap_timer.sv
module edge_gap_timer #(
  parameter int PERIOD      = 240,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic gap_in,
  output logic gap_status,
  output logic capture_pulse,
  output logic expire_pulse
);
  localparam int CNT_W = $clog2(PERIOD + 1);

  egt_pkg::egt_edges_t edges;
  logic             rise_evt;
  logic             fall_evt;
  logic             armed;
  logic             arm_evt;
  logic             cap_evt;
  logic             expire_evt;
  logic [CNT_W-1:0] count;

  egt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (gap_in),
    .edges    (edges)
  );

  assign rise_evt = edges.rise;
  assign fall_evt = edges.fall;

  egt_window_ctr #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .rise       (rise_evt),
    .armed      (armed),
    .arm_evt    (arm_evt),
    .cap_evt    (cap_evt),
    .expire_evt (expire_evt),
    .count      (count),
    .cap_q      (capture_pulse),
    .tc_q       (expire_pulse)
  );

  egt_status u_status (
    .clk        (clk),
    .rst        (rst),
    .cap_evt    (cap_evt),
    .fall_evt   (fall_evt),
    .expire_evt (expire_evt),
    .status_q   (gap_status)
  );
endmodule

// File: rtl/egt_checker.sv
module egt_checker #(
  parameter int PERIOD = 240,
  parameter int CNT_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rise_evt,
  input logic             fall_evt,
  input logic             armed,
  input logic             arm_evt,
  input logic [CNT_W-1:0] count,
  input logic             cap_pulse,
  input logic             tc_pulse,
  input logic             status_out
);
  localparam int AGE_W = CNT_W + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst)                 age_q <= '0;
    else if (arm_evt)        age_q <= AGE_W'(1);
    else if (age_q != '0 && age_q != AGE_MAX) age_q <= age_q + AGE_W'(1);
  end

  p_edge_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(rise_evt && fall_evt));

  p_arm_load_r2: assert property (@(posedge clk) disable iff (rst)
    arm_evt |=> count == CNT_W'(PERIOD));

  p_fall_no_cap_r3: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> !cap_pulse);

  p_cap_single_r4: assert property (@(posedge clk) disable iff (rst)
    cap_pulse |=> !cap_pulse);

  p_cap_low_r5: assert property (@(posedge clk) disable iff (rst)
    cap_pulse |-> !status_out);

  p_tc_high_r6: assert property (@(posedge clk) disable iff (rst)
    (tc_pulse && !cap_pulse) |-> status_out);

  p_tc_age_r7: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> age_q == AGE_W'(PERIOD + 1));

  p_tc_idle_r7: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> !armed);

  p_fall_high_r8: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> status_out);

  p_arm_no_cap_r9: assert property (@(posedge clk) disable iff (rst)
    arm_evt |=> !cap_pulse);

  p_no_reload_r10: assert property (@(posedge clk) disable iff (rst)
    (rise_evt && armed && count > CNT_W'(1)) |=> count == $past(count) - CNT_W'(1));

  p_reset_r11: assert property (@(posedge clk)
    rst |=> (status_out && !cap_pulse && !tc_pulse && !armed));
endmodule

bind edge_gap_timer egt_checker #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rise_evt   (rise_evt),
  .fall_evt   (fall_evt),
  .armed      (armed),
  .arm_evt    (arm_evt),
  .count      (count),
  .cap_pulse  (capture_pulse),
  .tc_pulse   (expire_pulse),
  .status_out (gap_status)
);

// File: tb/test_edge_gap_timer.sv
`timescale 1ns/1ps
module test_edge_gap_timer;
  localparam int P = 240;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gap_in = 1'b0;
  logic gap_status, capture_pulse, expire_pulse;

  int checks = 0;
  int fails  = 0;
  int t      = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  edge_gap_timer #(.PERIOD(P)) i_edge_gap_timer (
    .clk           (clk),
    .rst           (rst),
    .gap_in        (gap_in),
    .gap_status    (gap_status),
    .capture_pulse (capture_pulse),
    .expire_pulse  (expire_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle model built from the requirements: delay line of three stages,
  // window open from the arming edge until PERIOD edges later.
  logic m_d1, m_d2, m_d3;
  logic m_cap, m_tc, m_stat, m_armev;
  int   m_arm, n;

  function automatic logic f_status(input logic cur, input logic cap,
                                    input logic fall, input logic tc);
    logic r;
    r = cur;
    if (tc || fall) r = 1'b1;
    if (cap) r = 1'b0;
    return r;
  endfunction

  always @(posedge clk) begin
    logic rise, fall, was_armed;
    if (rst) begin
      m_d1 = 0; m_d2 = 0; m_d3 = 0; m_arm = -1;
      m_cap = 0; m_tc = 0; m_stat = 1; m_armev = 0; n = 0;
    end else begin
      n++;
      rise      = m_d2 && !m_d3;
      fall      = !m_d2 && m_d3;
      was_armed = (m_arm >= 0);
      m_cap     = rise && was_armed;
      m_tc      = was_armed && (n == m_arm + P);
      m_armev   = rise && !was_armed;
      if (m_tc) m_arm = -1;
      if (m_armev) m_arm = n;
      m_stat = f_status(m_stat, m_cap, fall, m_tc);
      m_d3 = m_d2; m_d2 = m_d1; m_d1 = gap_in;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(capture_pulse == m_cap, m_armev ? "R9 arming edge" : "R4 capture",
          capture_pulse, m_cap);
      chk(expire_pulse == m_tc, "R7 expiry", expire_pulse, m_tc);
      chk(gap_status == m_stat, "R5 status", gap_status, m_stat);
    end
  end

  task automatic step();
    @(negedge clk);
    t++;
  endtask

  task automatic go(input int j);
    while (t < j) step();
  endtask

  task automatic idle_wait();
    gap_in = 1'b0;
    repeat (2 * P + 10) @(negedge clk);
    t = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk(gap_status == 1'b1, "R11 reset status", gap_status, 1);
    chk(capture_pulse == 1'b0, "R11 reset capture", capture_pulse, 0);
    chk(expire_pulse == 1'b0, "R11 reset expiry", expire_pulse, 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    idle_wait();

    // Close pair, fall mid-window, expiry, re-arm.
    gap_in = 1; go(1); gap_in = 0; go(2); gap_in = 1;
    go(3); chk(capture_pulse == 0, "R9 arm only", capture_pulse, 0);
    go(4); chk(capture_pulse == 0, "R1 latency early", capture_pulse, 0); gap_in = 0;
    go(5); chk(capture_pulse == 1, "R1 latency", capture_pulse, 1);
           chk(gap_status == 0, "R5 low on capture", gap_status, 0);
    go(6); chk(capture_pulse == 0, "R4 one cycle", capture_pulse, 0);
    go(7); chk(gap_status == 1, "R8 fall high", gap_status, 1);
           chk(capture_pulse == 0, "R3 fall no capture", capture_pulse, 0);
    go(P + 2); chk(expire_pulse == 0, "R2 not early", expire_pulse, 0);
    go(P + 3); chk(expire_pulse == 1, "R10 window end kept", expire_pulse, 1);
               chk(gap_status == 1, "R6 expiry high", gap_status, 1);
    gap_in = 1;
    go(P + 4); gap_in = 0;
    go(P + 5); gap_in = 1;
    go(P + 6); chk(capture_pulse == 0, "R7 rearm no capture", capture_pulse, 0);
    go(P + 8); chk(capture_pulse == 1, "R7 fresh window", capture_pulse, 1);
    idle_wait();

    // Second edge on the last counted edge.
    gap_in = 1; go(1); gap_in = 0; go(P); gap_in = 1;
    go(P + 3); chk(capture_pulse == 1 && expire_pulse == 1, "R6 same edge",
                   {capture_pulse, expire_pulse}, 3);
               chk(gap_status == 0, "R6 capture wins", gap_status, 0);
    idle_wait();

    // One clock too late.
    gap_in = 1; go(1); gap_in = 0; go(P + 1); gap_in = 1;
    go(P + 3); chk(expire_pulse == 1, "R7 expiry before late edge", expire_pulse, 1);
    go(P + 4); chk(capture_pulse == 0, "R7 late edge rearms", capture_pulse, 0);
    idle_wait();

    // Several captures in one window.
    gap_in = 1; go(1); gap_in = 0;
    for (int k = 0; k < 5; k++) begin
      go(10 + 10 * k); gap_in = 1;
      go(12 + 10 * k); gap_in = 0;
      go(13 + 10 * k); chk(capture_pulse == 1, "R10 repeated capture", capture_pulse, 1);
    end
    go(P + 3); chk(expire_pulse == 1, "R10 no reload", expire_pulse, 1);
    idle_wait();

    // Reset inside an armed window after a capture.
    gap_in = 1; go(1); gap_in = 0; go(2); gap_in = 1; go(6);
    rst = 1; go(8);
    chk(gap_status == 1 && capture_pulse == 0 && expire_pulse == 0, "R11 mid reset",
        {gap_status, capture_pulse, expire_pulse}, 4);
    gap_in = 0; rst = 0;
    idle_wait();

    // Random gaps, some near the window boundary.
    for (int i = 0; i < 300; i++) begin
      int h, l;
      h = $urandom_range(1, 6);
      if ($urandom_range(0, 3) == 0) l = $urandom_range(P - 8, P + 8);
      else                           l = $urandom_range(1, P + 40);
      gap_in = 1;
      repeat (h) @(negedge clk);
      gap_in = 0;
      repeat (l) @(negedge clk);
    end
    repeat (P + 10) @(negedge clk);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule